// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block gathers up to 32 interrupt request lines into one request to the processor. A build-time mask sets the kind of each line. An edge line records one request each time it rises. A level line records a request for as long as it stays high. Recorded requests sit in a status word. An enable word masks that status word, and the masked result is the pending word. A vector location reports the index of the lowest-numbered pending line. The single output to the processor is high when the output-enable control bit is set and at least one line is pending.

Software reaches the block through a word-addressed bus with a 3-bit address, a write strobe, 32-bit write data and combinational 32-bit read data. All accesses are full words. Software can acknowledge requests by writing ones. It can set or clear enable bits through two separate alias locations. It can also write the status word directly to raise requests from software. Direct status writes take effect only while hardware capture is switched off.

The word addresses are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 control. The control word has two bits. Bit 0 enables the output. Bit 1 enables hardware capture.

Top module: `intc_vec`

## Requirements
- R1: After reset, the following read as zero: status, enable and control. The vector reads 0xFFFFFFFF and irq_out is low.
- R2: Pending (address 1) always reads as status AND enable.
- R3: The vector (address 6) reads the index of the lowest set pending bit, for example 0 for bit 0 and 31 for bit 31. When nothing is pending it reads 0xFFFFFFFF.
- R4: irq_out is high exactly when control bit 0 is 1 and pending is non-zero.
- R5: A write to control (address 7) keeps only data bits 1:0. Reading address 7 returns those two bits, with zeros above them.
- R6: A write to acknowledge (address 3) clears every status bit whose data bit is 1. All other status bits are left as they were.
- R7: A write to set-enable (address 4) ORs the data into enable. A write to clear-enable (address 5) clears the enable bits whose data bits are 1.
- R8: A write to status (address 0) loads the data when control bit 1 is 0. When control bit 1 is 1, the write is ignored.
- R9: While control bit 1 is 1, each level line (mask bit 0) that is high sets its status bit on every clock. An acknowledge of that bit has no lasting effect while the line stays high. While control bit 1 is 0, level lines are not captured.
- R10: While control bit 1 is 1, each rising transition of an edge line (mask bit 1) sets its status bit once. The bit stays set after the line falls and is cleared only by an acknowledge. A line held high after its acknowledge does not set the bit again. A rise that happens while control bit 1 is 0 is lost.
- R11: Writes to pending and vector are ignored. Acknowledge, set-enable and clear-enable read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | N | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Every stored bit can be read back on the cycle after the write or capture that changed it. This holds for status, enable and the control bits. A wrong bit therefore shows in the next read of status, pending or vector, and it shows on irq_out in that same cycle. Edge capture has one extra register stage, the previous-cycle copy of the inputs. A fault there shows as a status bit that comes back after an acknowledge, or as a rise that should have been lost but was kept. In both cases the fault is visible one clock after the input changes.

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_we,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [N-1:0] irq_in,
  output logic         irq_out
);

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_PEND = 3'd1;
  localparam logic [2:0] A_ENAB = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_SETE = 3'd4;
  localparam logic [2:0] A_CLRE = 3'd5;
  localparam logic [2:0] A_VEC  = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd7;

  logic [N-1:0] status_q, enable_q, in_q;
  logic [N-1:0] status_d, enable_d;
  logic [N-1:0] pending, rise, hw_set, wmask;
  logic [1:0]   mer_q;
  logic [31:0]  vector;
  logic         wr_stat, wr_ack, wr_sete, wr_clre, wr_ctrl;

  assign wmask   = bus_wdata[N-1:0];
  assign wr_stat = bus_we && (bus_addr == A_STAT);
  assign wr_ack  = bus_we && (bus_addr == A_ACK);
  assign wr_sete = bus_we && (bus_addr == A_SETE);
  assign wr_clre = bus_we && (bus_addr == A_CLRE);
  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

  assign rise    = irq_in & ~in_q;
  assign hw_set  = mer_q[1] ? ((irq_in & ~EDGE_MASK) | (rise & EDGE_MASK)) : '0;
  assign pending = status_q & enable_q;
  assign irq_out = mer_q[0] && (pending != '0);

  always_comb begin
    status_d = status_q;
    if (wr_stat && !mer_q[1]) status_d = wmask;
    if (wr_ack) status_d = status_d & ~wmask;
    status_d = status_d | hw_set;
  end

  always_comb begin
    enable_d = enable_q;
    if (wr_sete) enable_d = enable_d | wmask;
    if (wr_clre) enable_d = enable_d & ~wmask;
  end

  always_comb begin
    vector = '1;
    for (int i = N - 1; i >= 0; i--)
      if (pending[i]) vector = 32'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      in_q     <= '0;
      mer_q    <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      in_q     <= irq_in;
      if (wr_ctrl) mer_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = 32'(status_q);
      A_PEND:  bus_rdata = 32'(pending);
      A_ENAB:  bus_rdata = 32'(enable_q);
      A_VEC:   bus_rdata = vector;
      A_CTRL:  bus_rdata = {30'd0, mer_q};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   bus_addr,
  input logic         bus_we,
  input logic [31:0]  bus_wdata,
  input logic [N-1:0] irq_in,
  input logic         irq_out,
  input logic [N-1:0] status_q,
  input logic [N-1:0] enable_q,
  input logic [1:0]   mer_q
);

  AST_IRQ_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mer_q[0] && enable_q != '0)); // R4

  AST_CTRL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd7) |=> (mer_q == $past(bus_wdata[1:0]))); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3 && !mer_q[1]) |=> ((status_q & $past(bus_wdata[N-1:0])) == '0)); // R6

  AST_SET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd4) |=> ((enable_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R7

  AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && mer_q[1] && irq_in == '0) |=> $stable(status_q)); // R8

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mer_q[1] |=> ((status_q & $past(irq_in & ~EDGE_MASK)) == $past(irq_in & ~EDGE_MASK))); // R9

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && (bus_addr == 3'd3 || bus_addr == 3'd0))) |=> ((status_q & EDGE_MASK & $past(status_q)) == ($past(status_q) & EDGE_MASK))); // R10

endmodule

bind intc_vec intc_vec_chk #(.N(N), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_in(irq_in), .irq_out(irq_out),
  .status_q(status_q), .enable_q(enable_q), .mer_q(mer_q)
);

// File: tb/tb_intc_vec.sv
module tb_intc_vec;
  localparam logic [31:0] EMASK = 32'hFFFF_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_out;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  intc_vec #(.N(32), .EDGE_MASK(EMASK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        exp_irq;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t TABLE [NSTEP] = '{
    '{1'b1, 3'd0, 32'h0000_00A4, 32'h0, 1'b0, 4'd8},   // R8
    '{1'b0, 3'd0, 32'h0, 32'h0000_00A4, 1'b0, 4'd8},   // R8
    '{1'b0, 3'd1, 32'h0, 32'h0, 1'b0, 4'd2},           // R2
    '{1'b0, 3'd6, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd3},   // R3
    '{1'b1, 3'd4, 32'h0000_00F0, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, 3'd2, 32'h0, 32'h0000_00F0, 1'b0, 4'd7},   // R7
    '{1'b0, 3'd1, 32'h0, 32'h0000_00A0, 1'b0, 4'd2},   // R2
    '{1'b0, 3'd6, 32'h0, 32'h0000_0005, 1'b0, 4'd3},   // R3
    '{1'b1, 3'd7, 32'hFFFF_FFFD, 32'h0, 1'b1, 4'd5},   // R5
    '{1'b0, 3'd7, 32'h0, 32'h0000_0001, 1'b1, 4'd5},   // R5
    '{1'b1, 3'd5, 32'h0000_0020, 32'h0, 1'b1, 4'd7},   // R7
    '{1'b0, 3'd2, 32'h0, 32'h0000_00D0, 1'b1, 4'd7},   // R7
    '{1'b0, 3'd6, 32'h0, 32'h0000_0007, 1'b1, 4'd3},   // R3
    '{1'b1, 3'd3, 32'h0000_0080, 32'h0, 1'b0, 4'd6},   // R6
    '{1'b0, 3'd0, 32'h0, 32'h0000_0024, 1'b0, 4'd6},   // R6
    '{1'b0, 3'd1, 32'h0, 32'h0, 1'b0, 4'd4},           // R4
    '{1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd1, 32'h0, 32'h0, 1'b0, 4'd11},          // R11
    '{1'b1, 3'd6, 32'h0000_0003, 32'h0, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd6, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd3, 32'h0, 32'h0, 1'b0, 4'd11},          // R11
    '{1'b0, 3'd4, 32'h0, 32'h0, 1'b0, 4'd11}           // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_we = 0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    irq_in[idx] = 1;
    @(negedge clk);
    irq_in[idx] = 0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, 32'h0, "R1 status");
    rd(3'd2, 32'h0, "R1 enable");
    rd(3'd7, 32'h0, "R1 control");
    rd(3'd6, 32'hFFFF_FFFF, "R1 vector");
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);

    for (int i = 0; i < NSTEP; i++) begin
      if (TABLE[i].we) wr(TABLE[i].addr, TABLE[i].data);
      else rd(TABLE[i].addr, TABLE[i].exp, $sformatf("R%0d step %0d", TABLE[i].req, i));
      check($sformatf("R%0d irq step %0d", TABLE[i].req, i), {31'd0, irq_out}, {31'd0, TABLE[i].exp_irq});
    end

    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h3);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, 32'h0, "R8 status write locked");

    @(negedge clk); irq_in[3] = 1;
    @(negedge clk);
    rd(3'd0, 32'h0000_0008, "R9 level captured");
    wr(3'd3, 32'h0000_0008);
    rd(3'd0, 32'h0000_0008, "R9 ack while high");
    irq_in[3] = 0;
    wr(3'd3, 32'h0000_0008);
    rd(3'd0, 32'h0, "R9 ack after fall");

    pulse(20);
    rd(3'd0, 32'h0010_0000, "R10 edge sticky after fall");
    wr(3'd3, 32'h0010_0000);
    @(negedge clk);
    rd(3'd0, 32'h0, "R10 edge cleared once");
    @(negedge clk); irq_in[21] = 1;
    @(negedge clk);
    wr(3'd3, 32'h0020_0000);
    repeat (2) @(negedge clk);
    rd(3'd0, 32'h0, "R10 held high no recapture");
    irq_in[21] = 0;

    wr(3'd7, 32'h1);
    pulse(22);
    @(negedge clk); irq_in[4] = 1;
    @(negedge clk);
    rd(3'd0, 32'h0, "R9 level ignored capture off");
    irq_in[4] = 0;
    wr(3'd7, 32'h3);
    @(negedge clk);
    rd(3'd0, 32'h0, "R10 edge lost capture off");

    wr(3'd7, 32'h1);
    wr(3'd0, 32'h8000_0001);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0, "R3 vector bit0");
    check("R4 irq on", {31'd0, irq_out}, 32'd1);
    wr(3'd3, 32'h0000_0001);
    rd(3'd6, 32'h0000_001F, "R3 vector bit31");
    rd(3'd1, 32'h8000_0000, "R2 pending bit31");
    wr(3'd7, 32'h0);
    check("R4 irq gated off", {31'd0, irq_out}, 32'd0);

    finish_run();
  end
endmodule